// File: doc/BRIEF.md
# ATA Multiword DMA Burst Sequencer

This block is the digital core of a host controller's multiword DMA engine for an ATA disk interface. It has a start pulse, a direction bit and a word count, and the device signals that it is ready through its request line. From these the block drives the active-low acknowledge, the active-low read and write strobes, and an enable for the external data buffer. Every phase of the bus handshake is an 8-bit count of system clock periods set by the host: acknowledge-to-first-strobe setup, strobe-active width, strobe recovery, two acknowledge hold counts, and the buffer-enable turn-on and turn-off delays.

Write words arrive on a valid/ready input. The accepted word is driven on the outgoing data bus while its write strobe is active, and it stays there afterwards. Read words are captured from the incoming data bus at the clock edge where the read strobe negates, and they are presented with a single-cycle valid pulse. If the device drops its request, the burst stops at the next word boundary and waits. The burst ends when all programmed words have moved.

Top module: `mdma_timing_gen`

## Requirements
- R1: While reset is applied and right after it, `dmack_n_o`, `dior_n_o` and `diow_n_o` are high, and `buf_en_o` and `rd_valid_o` are low.
- R2: A burst starts only on a clock where `start_i` is 1, `word_cnt_i` is nonzero and `dmarq_i` is 1. In any other case the acknowledge and both strobes stay high. Raising `dmarq_i` later without a new start pulse does not start a burst.
- R3: The first strobe of a burst falls exactly eff(`t_m_i`) clocks after `dmack_n_o` falls, provided the request is high and, for writes, a word is valid at that point. A strobe is only ever low while `dmack_n_o` is low.
- R4: Each strobe stays low for exactly eff(`t_d_i`) clocks.
- R5: Between two words the strobe stays high for at least eff(`t_k_i`) clocks. The gap is exactly eff(`t_k_i`) when the request stays high and write data is ready.
- R6: A burst produces exactly `word_cnt_i` strobe pulses. `dmack_n_o` rises exactly max(eff(`t_k_i`), eff(`t_jn_i`)) clocks after the last strobe rises.
- R7: For every timing field, eff(x) is 1 when x is 0 and x otherwise, so each phase lasts at least one clock.
- R8: If `dmarq_i` is 0 at a word boundary, no strobe falls until `dmarq_i` has been sampled 1 again. The words left are not lost.
- R9: `buf_en_o` rises eff(`t_on_i`) clocks after `dmack_n_o` falls and falls eff(`t_off_i`) clocks after `dmack_n_o` rises.
- R10: A write word is taken on a clock where `wr_valid_i` and `wr_ready_o` are both 1. It appears on `bus_wr_o` on the clock where `diow_n_o` falls and stays unchanged through the low phase and the eff(`t_k_i`) clocks that follow. If no word is valid at a boundary, the strobe waits.
- R11: With `dir_rd_i`=1 only `dior_n_o` pulses, and with `dir_rd_i`=0 only `diow_n_o` pulses. On a read, `bus_rd_i` is captured at the edge where `dior_n_o` rises and shows on `rd_data_o`, with `rd_valid_o` high for that one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counts are in its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock request to begin a burst |
| dir_rd_i | input | 1 | 1 = read from device, 0 = write to device |
| word_cnt_i | input | CNT_W | Number of 16-bit words in the burst |
| t_m_i | input | TW | Clocks from acknowledge to first strobe |
| t_d_i | input | TW | Strobe active clocks |
| t_k_i | input | TW | Strobe recovery clocks |
| t_jn_i | input | TW | Second acknowledge-hold count |
| t_on_i | input | TW | Buffer-enable turn-on delay |
| t_off_i | input | TW | Buffer-enable turn-off delay |
| dmarq_i | input | 1 | Device request, active high |
| wr_data_i | input | DW | Write word offered |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Sequencer can take a write word this clock |
| bus_rd_i | input | DW | Data bus from device |
| bus_wr_o | output | DW | Data bus to device |
| dmack_n_o | output | 1 | DMA acknowledge, active low |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| buf_en_o | output | 1 | External data buffer enable |
| rd_data_o | output | DW | Captured read word |
| rd_valid_o | output | 1 | One-clock pulse for a new read word |

## Verification
A phase counter that loads the wrong field or slips by one shows up as a strobe edge one or more clocks away from its programmed position, and that is visible on the first word of the burst. A wrong remaining-word count shows up at the end of the burst as an extra or missing strobe pulse, or as a hold time taken from the recovery count instead of the larger of the two hold counts. A broken buffer timer shows up as a buffer-enable edge displaced from the acknowledge edge that triggers it. A wrong data path shows up at the first strobe as a scoreboard mismatch, either on the captured read word or on the outgoing write word.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOV,
        PH_HOLD
    } phase_e;

    localparam int NUM_TIMES = 6;
    localparam int TI_M      = 0;
    localparam int TI_D      = 1;
    localparam int TI_K      = 2;
    localparam int TI_JN     = 3;
    localparam int TI_ON     = 4;
    localparam int TI_OFF    = 5;

endpackage

// File: rtl/mdma_cfg_norm.sv
module mdma_cfg_norm #(
    parameter int TW = 8,
    parameter int N  = 6
) (
    input  logic [N-1:0][TW-1:0] raw_i,
    output logic [N-1:0][TW-1:0] eff_o
);
    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    // a zero count becomes one so every phase spans a clock (R7)
    for (genvar g = 0; g < N; g++) begin : g_norm
        assign eff_o[g] = (raw_i[g] == '0) ? ONE : raw_i[g];
    end

endmodule

// File: rtl/mdma_buf_timer.sv
module mdma_buf_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_n_i,
    input  logic [TW-1:0] on_cnt_i,
    input  logic [TW-1:0] off_cnt_i,
    output logic          buf_en_o
);
    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] cnt;
        logic          tgt;
        logic          en;
    } tmr_t;

    localparam tmr_t TMR_RST = '{prev: 1'b1, cnt: '0, tgt: 1'b0, en: 1'b0};

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.prev = ack_n_i;
        if (tmr_q.prev && !ack_n_i) begin
            if (on_cnt_i == ONE) begin
                tmr_d.en  = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = on_cnt_i - ONE;
                tmr_d.tgt = 1'b1;
            end
        end else if (!tmr_q.prev && ack_n_i) begin
            if (off_cnt_i == ONE) begin
                tmr_d.en  = 1'b0;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = off_cnt_i - ONE;
                tmr_d.tgt = 1'b0;
            end
        end else if (tmr_q.cnt == ONE) begin
            tmr_d.en  = tmr_q.tgt;
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= TMR_RST;
        else        tmr_q <= tmr_d;
    end

    assign buf_en_o = tmr_q.en;

    // the enable only turns on from a turn-on countdown begun while acknowledged (R9)
    p_buf_rise_in_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.en) |-> $past(!ack_n_i));

endmodule

// File: rtl/mdma_word_fsm.sv
module mdma_word_fsm
    import mdma_pkg::*;
#(
    parameter int TW    = 8,
    parameter int CNT_W = 16,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_rd_i,
    input  logic [CNT_W-1:0] words_i,
    input  logic             dmarq_i,
    input  logic [TW-1:0]    t_m_i,
    input  logic [TW-1:0]    t_d_i,
    input  logic [TW-1:0]    t_k_i,
    input  logic [TW-1:0]    t_jn_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [DW-1:0]    bus_rd_i,
    output logic [DW-1:0]    bus_wr_o,
    output logic             dmack_n_o,
    output logic             dior_n_o,
    output logic             diow_n_o,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o
);
    localparam logic [TW-1:0]    ONE_T = {{(TW-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ONE_W = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        phase_e           phase;
        logic [TW-1:0]    cnt;
        logic [CNT_W-1:0] words;
        logic             is_rd;
        logic             dmack_n;
        logic             dior_n;
        logic             diow_n;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic             rvalid;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase: PH_IDLE, cnt: '0, words: '0, is_rd: 1'b0,
        dmack_n: 1'b1, dior_n: 1'b1, diow_n: 1'b1,
        wdata: '0, rdata: '0, rvalid: 1'b0
    };

    seq_t st_d, st_q;
    logic go;
    logic [TW-1:0] hold_cnt;

    assign hold_cnt = (t_k_i >= t_jn_i) ? t_k_i : t_jn_i;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        wr_ready_o  = 1'b0;
        go          = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i && dmarq_i && (words_i != '0)) begin
                    st_d.phase   = PH_SETUP;
                    st_d.cnt     = t_m_i;
                    st_d.words   = words_i;
                    st_d.is_rd   = dir_rd_i;
                    st_d.dmack_n = 1'b0;
                end
            end
            PH_SETUP, PH_RECOV: begin
                if (st_q.cnt > ONE_T) begin
                    st_d.cnt = st_q.cnt - ONE_T;
                end else begin
                    wr_ready_o = dmarq_i && !st_q.is_rd;
                    go         = dmarq_i && (st_q.is_rd || wr_valid_i);
                    if (go) begin
                        st_d.phase = PH_STROBE;
                        st_d.cnt   = t_d_i;
                        if (st_q.is_rd) begin
                            st_d.dior_n = 1'b0;
                        end else begin
                            st_d.diow_n = 1'b0;
                            st_d.wdata  = wr_data_i;
                        end
                    end
                end
            end
            PH_STROBE: begin
                if (st_q.cnt > ONE_T) begin
                    st_d.cnt = st_q.cnt - ONE_T;
                end else begin
                    st_d.dior_n = 1'b1;
                    st_d.diow_n = 1'b1;
                    st_d.words  = st_q.words - ONE_W;
                    if (st_q.is_rd) begin
                        st_d.rdata  = bus_rd_i;
                        st_d.rvalid = 1'b1;
                    end
                    if (st_q.words == ONE_W) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = hold_cnt;
                    end else begin
                        st_d.phase = PH_RECOV;
                        st_d.cnt   = t_k_i;
                    end
                end
            end
            PH_HOLD: begin
                if (st_q.cnt > ONE_T) begin
                    st_d.cnt = st_q.cnt - ONE_T;
                end else begin
                    st_d.dmack_n = 1'b1;
                    st_d.phase   = PH_IDLE;
                end
            end
            default: st_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RST;
        else        st_q <= st_d;
    end

    assign dmack_n_o  = st_q.dmack_n;
    assign dior_n_o   = st_q.dior_n;
    assign diow_n_o   = st_q.diow_n;
    assign bus_wr_o   = st_q.wdata;
    assign rd_data_o  = st_q.rdata;
    assign rd_valid_o = st_q.rvalid;

    // leaving idle needs a qualified start (R2)
    p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && $past(st_q.phase) == PH_IDLE)
            |-> $past(start_i && dmarq_i && (words_i != '0)));

    // strobes live only inside the acknowledge window (R3)
    p_strobe_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.dior_n || !st_q.diow_n) |-> !st_q.dmack_n);

    // hold phase is entered only after the last word (R6)
    p_hold_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HOLD) |-> (st_q.words == '0));

    // with the request low and strobes idle, no strobe starts next (R8)
    p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dior_n && st_q.diow_n && !dmarq_i) |=> (st_q.dior_n && st_q.diow_n));

    // outgoing word is frozen while the write strobe stays low (R10)
    p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.diow_n && $past(!st_q.diow_n)) |-> $stable(st_q.wdata));

    // never both strobes at once (R11)
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!st_q.dior_n && !st_q.diow_n));

    // read valid coincides with the read strobe negating (R11)
    p_rvalid_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rvalid |-> $rose(st_q.dior_n));

endmodule

// File: rtl/mdma_timing_gen.sv
module mdma_timing_gen
    import mdma_pkg::*;
#(
    parameter int TW    = 8,
    parameter int CNT_W = 16,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             dir_rd_i,
    input  logic [CNT_W-1:0] word_cnt_i,
    input  logic [TW-1:0]    t_m_i,
    input  logic [TW-1:0]    t_d_i,
    input  logic [TW-1:0]    t_k_i,
    input  logic [TW-1:0]    t_jn_i,
    input  logic [TW-1:0]    t_on_i,
    input  logic [TW-1:0]    t_off_i,
    input  logic             dmarq_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             wr_valid_i,
    output logic             wr_ready_o,
    input  logic [DW-1:0]    bus_rd_i,
    output logic [DW-1:0]    bus_wr_o,
    output logic             dmack_n_o,
    output logic             dior_n_o,
    output logic             diow_n_o,
    output logic             buf_en_o,
    output logic [DW-1:0]    rd_data_o,
    output logic             rd_valid_o
);
    logic [NUM_TIMES-1:0][TW-1:0] raw_t, eff_t;
    logic ack_n;

    assign raw_t[TI_M]   = t_m_i;
    assign raw_t[TI_D]   = t_d_i;
    assign raw_t[TI_K]   = t_k_i;
    assign raw_t[TI_JN]  = t_jn_i;
    assign raw_t[TI_ON]  = t_on_i;
    assign raw_t[TI_OFF] = t_off_i;

    mdma_cfg_norm #(.TW(TW), .N(NUM_TIMES)) u_norm (
        .raw_i (raw_t),
        .eff_o (eff_t)
    );

    mdma_word_fsm #(.TW(TW), .CNT_W(CNT_W), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dir_rd_i   (dir_rd_i),
        .words_i    (word_cnt_i),
        .dmarq_i    (dmarq_i),
        .t_m_i      (eff_t[TI_M]),
        .t_d_i      (eff_t[TI_D]),
        .t_k_i      (eff_t[TI_K]),
        .t_jn_i     (eff_t[TI_JN]),
        .wr_data_i  (wr_data_i),
        .wr_valid_i (wr_valid_i),
        .wr_ready_o (wr_ready_o),
        .bus_rd_i   (bus_rd_i),
        .bus_wr_o   (bus_wr_o),
        .dmack_n_o  (ack_n),
        .dior_n_o   (dior_n_o),
        .diow_n_o   (diow_n_o),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    mdma_buf_timer #(.TW(TW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n_i   (ack_n),
        .on_cnt_i  (eff_t[TI_ON]),
        .off_cnt_i (eff_t[TI_OFF]),
        .buf_en_o  (buf_en_o)
    );

    assign dmack_n_o = ack_n;

endmodule

// File: tb/mdma_timing_gen_tb.sv
module mdma_timing_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dir_rd_i = 1'b0;
    logic [15:0] word_cnt_i = '0;
    logic [7:0]  t_m_i = 8'd1, t_d_i = 8'd1, t_k_i = 8'd1;
    logic [7:0]  t_jn_i = 8'd1, t_on_i = 8'd1, t_off_i = 8'd1;
    logic        dmarq_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        wr_valid_i = 1'b0;
    logic        wr_ready_o;
    logic [15:0] bus_rd_i = '0;
    logic [15:0] bus_wr_o;
    logic        dmack_n_o, dior_n_o, diow_n_o, buf_en_o;
    logic [15:0] rd_data_o;
    logic        rd_valid_o;

    always #10 clk = ~clk;

    mdma_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_rd_i(dir_rd_i),
        .word_cnt_i(word_cnt_i), .t_m_i(t_m_i), .t_d_i(t_d_i), .t_k_i(t_k_i),
        .t_jn_i(t_jn_i), .t_on_i(t_on_i), .t_off_i(t_off_i), .dmarq_i(dmarq_i),
        .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
        .bus_rd_i(bus_rd_i), .bus_wr_o(bus_wr_o), .dmack_n_o(dmack_n_o),
        .dior_n_o(dior_n_o), .diow_n_o(diow_n_o), .buf_en_o(buf_en_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
    );

    int n_checks = 0;
    int n_err = 0;
    int e_m, e_d, e_k, e_hold, e_on, e_off, e_words;
    bit gap_exact = 1'b1;
    bit mode_rd = 1'b1;
    string ctx = "";
    logic [15:0] exp_q[$];
    int strobes = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s%s %s: actual %0d expected %0d", req, ctx, what, act, expv);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // monitor and device model: samples at falling edges
    initial begin
        int cyc = 0, t_af = 0, t_ar = 0, t_sf = 0, t_sr = 0;
        bit p_ack = 1, p_s = 1, p_buf = 0, p_rq = 0, first = 0;
        bit wr_moved = 0, wrong = 0;
        logic [15:0] cur_w = '0, w;
        logic [15:0] pat = 16'h3C00;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (p_ack && !dmack_n_o) begin
                    t_af = cyc; strobes = 0; first = 1; wr_moved = 0; wrong = 0;
                end
                if ((mode_rd && !diow_n_o) || (!mode_rd && !dior_n_o)) wrong = 1;
                if (p_s && !(dior_n_o && diow_n_o)) begin
                    chk(p_rq, "R8", " strobe fell after request low", 0, 1);
                    if (first) chk(cyc - t_af == e_m, "R3", " setup clocks", cyc - t_af, e_m);
                    else if (gap_exact) chk(cyc - t_sr == e_k, "R5", " recovery clocks", cyc - t_sr, e_k);
                    else chk(cyc - t_sr >= e_k, "R5", " recovery too short", cyc - t_sr, e_k);
                    first = 0; t_sf = cyc; strobes++;
                    if (mode_rd) begin
                        pat = pat + 16'h0111;
                        bus_rd_i = pat;
                        exp_q.push_back(pat);
                    end else if (exp_q.size() == 0) begin
                        chk(0, "R10", " write word with empty scoreboard", 0, 1);
                    end else begin
                        w = exp_q.pop_front();
                        chk(bus_wr_o == w, "R10", " write word", int'(bus_wr_o), int'(w));
                        cur_w = w;
                    end
                end
                if (!p_s && dior_n_o && diow_n_o) begin
                    chk(cyc - t_sf == e_d, "R4", " strobe low clocks", cyc - t_sf, e_d);
                    t_sr = cyc;
                    if (mode_rd) chk(rd_valid_o, "R11", " valid at read strobe rise", int'(rd_valid_o), 1);
                end
                if (!mode_rd && !dmack_n_o && strobes > 0) begin
                    if ((!diow_n_o || (cyc - t_sr < e_k)) && bus_wr_o != cur_w) wr_moved = 1;
                end
                if (rd_valid_o) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R11", " read valid with empty scoreboard", 0, 1);
                    end else begin
                        w = exp_q.pop_front();
                        chk(rd_data_o == w, "R11", " read word", int'(rd_data_o), int'(w));
                    end
                end
                if (!p_ack && dmack_n_o) begin
                    t_ar = cyc;
                    chk(cyc - t_sr == e_hold, "R6", " ack hold clocks", cyc - t_sr, e_hold);
                    chk(strobes == e_words, "R6", " strobe count", strobes, e_words);
                    chk(!wrong, "R11", " wrong-direction strobe", int'(wrong), 0);
                    if (!mode_rd) chk(!wr_moved, "R10", " write word moved", int'(wr_moved), 0);
                end
                if (!p_buf && buf_en_o) chk(cyc - t_af == e_on, "R9", " buffer on delay", cyc - t_af, e_on);
                if (p_buf && !buf_en_o) chk(cyc - t_ar == e_off, "R9", " buffer off delay", cyc - t_ar, e_off);
            end
            p_ack = dmack_n_o; p_s = dior_n_o && diow_n_o; p_buf = buf_en_o; p_rq = dmarq_i;
        end
    end

    // driver: programs a burst, feeds write words, optionally pauses the request
    task automatic run_burst(input bit rd, input int n, input int m, input int d,
                             input int k, input int jn, input int on, input int off,
                             input bit exact, input int stall_idx, input int pause_after);
        t_m_i = 8'(m); t_d_i = 8'(d); t_k_i = 8'(k);
        t_jn_i = 8'(jn); t_on_i = 8'(on); t_off_i = 8'(off);
        e_m = eff(m); e_d = eff(d); e_k = eff(k);
        e_hold = (eff(k) > eff(jn)) ? eff(k) : eff(jn);
        e_on = eff(on); e_off = eff(off); e_words = n;
        mode_rd = rd; gap_exact = exact;
        @(posedge clk); #2;
        dmarq_i = 1'b1; dir_rd_i = rd; word_cnt_i = 16'(n); start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        fork
            begin
                if (!rd) begin
                    for (int i = 0; i < n; i++) begin
                        if (i == stall_idx) begin
                            wr_valid_i = 1'b0;
                            repeat (5) @(posedge clk);
                            #2;
                        end
                        wr_data_i = 16'hA500 + 16'(i * 37);
                        exp_q.push_back(wr_data_i);
                        wr_valid_i = 1'b1;
                        do @(negedge clk); while (!wr_ready_o);
                        @(posedge clk); #2;
                    end
                    wr_valid_i = 1'b0;
                end
            end
            begin
                if (pause_after > 0) begin
                    do @(negedge clk); while (!(strobes == pause_after && dior_n_o && diow_n_o));
                    @(posedge clk); #2;
                    dmarq_i = 1'b0;
                    repeat (6) @(posedge clk);
                    #2;
                    dmarq_i = 1'b1;
                end
            end
            begin
                wait (dmack_n_o == 1'b0);
                wait (dmack_n_o == 1'b1);
                repeat (e_off + 4) @(posedge clk);
            end
        join
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        chk(dmack_n_o && dior_n_o && diow_n_o, "R1", " strobes high in reset", 0, 1);
        chk(!buf_en_o && !rd_valid_o, "R1", " enable and valid low in reset", 0, 1);
        @(posedge clk); #2; rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dmack_n_o && dior_n_o && diow_n_o && !buf_en_o, "R1", " idle after reset", 0, 1);

        // R2: zero word count never starts
        @(posedge clk); #2; dmarq_i = 1'b1; word_cnt_i = '0; start_i = 1'b1;
        @(posedge clk); #2; start_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(dmack_n_o, "R2", " ack with zero count", int'(dmack_n_o), 1);
        // R2: request low at start, later high without start
        @(posedge clk); #2; dmarq_i = 1'b0; word_cnt_i = 16'd3; start_i = 1'b1;
        @(posedge clk); #2; start_i = 1'b0; dmarq_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(dmack_n_o && dior_n_o && diow_n_o, "R2", " burst without qualified start", int'(dmack_n_o), 1);

        // read burst, exact timing (R3 R4 R5 R6 R9 R11)
        run_burst(1, 4, 3, 4, 2, 5, 2, 3, 1, -1, 0);
        // write burst with a late second word (R10, R5 lower bound)
        run_burst(0, 3, 2, 3, 4, 1, 1, 2, 0, 1, 0);
        // write burst, exact timing, hold from second count
        run_burst(0, 2, 1, 2, 1, 3, 3, 1, 1, -1, 0);
        // R7: every field zero behaves as one
        ctx = " (R7 zero fields)";
        run_burst(1, 2, 0, 0, 0, 0, 0, 0, 1, -1, 0);
        ctx = "";
        // R8: request drops after the second word
        run_burst(1, 4, 2, 2, 3, 2, 4, 2, 0, -1, 2);

        chk(exp_q.size() == 0, "R6", " scoreboard left over", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

endmodule